// File: doc/BRIEF.md
# Autovector Interrupt Level Encoder

This block assigns a 3-bit priority level to each interrupt source of a local processor and presents the highest level among the sources that are currently requesting service. It sits after the pending/enable stage. Its input is the vector of sources that are both pending and enabled. Its output is the level that a processor with autovectored interrupts compares against its own mask. A level of zero means that no interrupt is requested.

Each level code is stored in three byte-wide bit-plane registers. Plane p holds bit p of the code for every source column, so a source's code is gathered from the same column across the three planes. The eight columns cover sources 0 to 6 one-to-one. Column 7 is shared by the four highest sources, 7 to 10. Software programs the planes with byte writes to three consecutive plane addresses. The planes cannot be read back. The output level is held in a register.

Top module: `irq_lvl_enc`

## Requirements
- R1: After reset all three planes hold zero and the output level is 000, whatever the request vector is.
- R2: The code of source k (k from 0 to 6) is {plane2[k], plane1[k], plane0[k]}, with plane 2 as the most significant bit. For example, source 6 at level 6 takes plane0[6]=0, plane1[6]=1 and plane2[6]=1.
- R3: Sources 7, 8, 9 and 10 all take their code from column 7 of the three planes.
- R4: The output level is the largest code among the sources whose request bit is 1. It is 000 when no request bit is set.
- R5: A source whose code is 000 never raises the output above 000, even while it is requested.
- R6: A change of the request vector appears on the output after exactly one rising clock edge.
- R7: A write with wr_en=1 and wr_addr equal to 0, 1 or 2 replaces plane 0, 1 or 2 with wr_data at that edge. The new codes reach the output one edge later.
- R8: A write with wr_addr=3 changes no plane, and nothing changes any plane while wr_en=0.
- R9: When a plane write and a request change are presented in the same cycle, the output after that edge uses the new requests with the old codes. The output after the following edge uses the new codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Plane write strobe |
| wr_addr | input | 2 | Plane index (0, 1, 2; 3 is unused) |
| wr_data | input | 8 | Byte written to the selected plane |
| req_vec | input | 11 | Pending-and-enabled source vector |
| level | output | 3 | Highest requested level, registered |

## Verification
A plane write and a change of the request vector can land in the same clock cycle, and the two paths reach the output with different latency. The bench provokes this many times. Its random stimulus updates the requests on every cycle, so every random write collides with a request change. A directed case also moves a source's code and its request in the same cycle. Each result is compared with a cycle model that applies the new requests against the old planes first, and only then commits the write.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
   // Map a source index onto its level column; the top column is shared.
   function automatic int col_of(input int src, input int cols);
      return (src < cols - 1) ? src : cols - 1;
   endfunction
endpackage

// File: rtl/irq_lvl_planes.sv
module irq_lvl_planes #(
   parameter int COLS  = 8,
   parameter int LVL_W = 3,
   parameter int AW    = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [AW-1:0]                  wr_addr,
   input  logic [COLS-1:0]                wr_data,
   output logic [LVL_W-1:0][COLS-1:0]     planes
);
   genvar p;
   generate
      for (p = 0; p < LVL_W; p++) begin : g_plane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               planes[p] <= '0;
            else if (wr_en && (wr_addr == AW'(p)))
               planes[p] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_lvl_map.sv
module irq_lvl_map #(
   parameter int NUM_SRC = 11,
   parameter int COLS    = 8,
   parameter int LVL_W   = 3
) (
   input  logic [LVL_W-1:0][COLS-1:0]     planes,
   input  logic [NUM_SRC-1:0]             req_vec,
   output logic [NUM_SRC-1:0][LVL_W-1:0]  src_lvl
);
   import irq_lvl_pkg::*;
   genvar k, b;
   generate
      for (k = 0; k < NUM_SRC; k++) begin : g_src
         localparam int C = col_of(k, COLS);
         logic [LVL_W-1:0] code;
         for (b = 0; b < LVL_W; b++) begin : g_bit
            assign code[b] = planes[b][C];
         end
         assign src_lvl[k] = req_vec[k] ? code : '0;
      end
   endgenerate
endmodule

// File: rtl/irq_lvl_max.sv
module irq_lvl_max #(
   parameter int NUM_SRC = 11,
   parameter int LVL_W   = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0][LVL_W-1:0]  src_lvl,
   output logic [LVL_W-1:0]               level
);
   logic [LVL_W-1:0] mx;
   always_comb begin
      mx = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (src_lvl[i] > mx) mx = src_lvl[i];
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level <= '0;
            else        level <= mx;
         end
      end else begin : g_comb
         assign level = mx;
      end
   endgenerate
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc #(
   parameter int NUM_SRC = 11,
   parameter int COLS    = 8,
   parameter int LVL_W   = 3,
   parameter bit REG_OUT = 1'b1,
   localparam int AW     = (LVL_W > 1) ? $clog2(LVL_W) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [COLS-1:0]    wr_data,
   input  logic [NUM_SRC-1:0] req_vec,
   output logic [LVL_W-1:0]   level
);
   generate
      if (COLS < 1 || NUM_SRC < COLS) begin : g_bad_cols
         $error("irq_lvl_enc: NUM_SRC must be at least COLS and COLS at least 1");
      end
      if (LVL_W < 1) begin : g_bad_w
         $error("irq_lvl_enc: LVL_W must be at least 1");
      end
   endgenerate

   logic [LVL_W-1:0][COLS-1:0]    planes_q;
   logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;

   irq_lvl_planes #(.COLS(COLS), .LVL_W(LVL_W), .AW(AW)) u_planes (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .planes(planes_q)
   );

   irq_lvl_map #(.NUM_SRC(NUM_SRC), .COLS(COLS), .LVL_W(LVL_W)) u_map (
      .planes(planes_q), .req_vec(req_vec), .src_lvl(src_lvl)
   );

   irq_lvl_max #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .REG_OUT(REG_OUT)) u_max (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .level(level)
   );
endmodule

// File: rtl/irq_lvl_enc_chk.sv
module irq_lvl_enc_chk #(
   parameter int NUM_SRC = 11,
   parameter int COLS    = 8,
   parameter int LVL_W   = 3,
   parameter int AW      = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [AW-1:0]              wr_addr,
   input logic [NUM_SRC-1:0]         req_vec,
   input logic [LVL_W-1:0]           level,
   input logic [LVL_W-1:0][COLS-1:0] planes_q
);
   // R1: first sampled edge out of reset sees a zero level
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> level == '0);

   // R4: an empty request vector yields level zero one edge later
   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_vec == '0 |=> level == '0);

   // R5: with every code zero nothing is requested
   p_all_zero_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      planes_q == '0 |=> level == '0);

   // R3: the top source alone follows the shared column
   p_shared_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_vec == (NUM_SRC'(1) << (NUM_SRC - 1)) |=>
      level == LVL_W'({$past(planes_q[2][COLS-1]), $past(planes_q[1][COLS-1]),
                       $past(planes_q[0][COLS-1])}));

   // R6: quiet inputs keep the output still
   p_quiet_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(req_vec) && !$past(wr_en)) |=> $stable(level));

   // R8: an out-of-range plane index changes nothing
   p_bad_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || int'(wr_addr) >= LVL_W) |=> $stable(planes_q));
endmodule

bind irq_lvl_enc irq_lvl_enc_chk #(
   .NUM_SRC(NUM_SRC), .COLS(COLS), .LVL_W(LVL_W), .AW(AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .req_vec(req_vec), .level(level), .planes_q(planes_q)
);

// File: tb/irq_lvl_enc_tb.sv
module irq_lvl_enc_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [10:0] req_vec = '0;
   logic [2:0]  level;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] mp [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_lvl_enc u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .req_vec(req_vec), .level(level)
   );

   function automatic logic [2:0] exp_level(input logic [10:0] rq);
      logic [2:0] mx = '0;
      for (int k = 0; k < 11; k++) begin
         int c = (k < 7) ? k : 7;
         logic [2:0] lv = {mp[2][c], mp[1][c], mp[0][c]};
         if (rq[k] && lv > mx) mx = lv;
      end
      return mx;
   endfunction

   task automatic check(input string tag, input logic [2:0] exp);
      n_chk++;
      if (level !== exp) begin
         n_bad++;
         $display("FAIL %s: level=%0d expected=%0d", tag, level, exp);
      end
   endtask

   // One cycle: drive, clock, then compare against the model.
   task automatic cyc(input string tag, input logic en, input logic [1:0] a,
                      input logic [7:0] d, input logic [10:0] rq);
      logic [2:0] e;
      @(negedge clk);
      wr_en = en; wr_addr = a; wr_data = d; req_vec = rq;
      e = exp_level(rq);
      if (en && a != 2'd3) mp[a] = d;
      @(posedge clk); #1;
      check(tag, e);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: level=%0d expected=done", level);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [10:0] rq;
      logic        en;
      logic [1:0]  a;
      logic [7:0]  d;
      void'($urandom(32'd1234));
      for (int p = 0; p < 3; p++) mp[p] = '0;
      req_vec = 11'h7FF;
      repeat (3) @(posedge clk);
      #1 check("R1 reset", 3'd0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 check("R1 after release", 3'd0);
      cyc("R5 zero codes", 1'b0, 2'd0, 8'h00, 11'h7FF);

      // R2: source 6 at level 6
      cyc("R2 plane0", 1'b1, 2'd0, 8'h00, 11'h040);
      cyc("R2 plane1", 1'b1, 2'd1, 8'h40, 11'h040);
      cyc("R7 plane2", 1'b1, 2'd2, 8'h40, 11'h040);
      cyc("R2 src6 lvl6", 1'b0, 2'd0, 8'h00, 11'h040);
      // R3: column 7 at level 5, each shared source alone
      cyc("R3 col7 p0", 1'b1, 2'd0, 8'h80, 11'h000);
      cyc("R3 col7 p2", 1'b1, 2'd2, 8'hC0, 11'h000);
      for (int k = 7; k < 11; k++) cyc("R3 shared", 1'b0, 2'd0, 8'h00, 11'(1 << k));
      // R4: max of 6 and 5, and of nothing
      cyc("R4 max", 1'b0, 2'd0, 8'h00, 11'h440);
      cyc("R4 none", 1'b0, 2'd0, 8'h00, 11'h000);
      // R8: index 3 and idle strobe
      cyc("R8 addr3", 1'b1, 2'd3, 8'hFF, 11'h7FF);
      cyc("R8 after addr3", 1'b0, 2'd3, 8'hFF, 11'h7FF);
      cyc("R8 no strobe", 1'b0, 2'd1, 8'hFF, 11'h7FF);
      // R5: source 0 requested with code 0
      cyc("R5 level0 src", 1'b0, 2'd0, 8'h00, 11'h001);
      // R9: raise source 1 code and request it in the same cycle
      cyc("R9 same cycle", 1'b1, 2'd2, 8'hC2, 11'h002);
      cyc("R9 next edge", 1'b0, 2'd0, 8'h00, 11'h002);
      // R6: request step with stable codes
      cyc("R6 step", 1'b0, 2'd0, 8'h00, 11'h040);

      for (int i = 0; i < 600; i++) begin
         en = ($urandom % 3) == 0;
         a  = 2'($urandom);
         d  = 8'($urandom);
         rq = 11'($urandom) & 11'($urandom);
         cyc("R4 R9 random", en, a, d, rq);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule